// File: doc/BRIEF.md
# Hall Tachometer and Direction Detector

This block follows three Hall sensor bits from a brushless motor and turns them into a tachometer square wave, a rotation-direction bit and a running count of steps. The Hall bits must already be synchronised to the block clock. Each clock cycle the current Hall code is decoded into one of six electrical stages. The decoded stage is then compared with the last stage the block accepted. A move of one stage forward or one stage backward is a valid step. A valid step toggles the tachometer, sets the direction and advances the counter. The tachometer therefore runs at three full cycles per electrical revolution.

Codes that cannot occur on a healthy sensor set (all bits low or all bits high) are rejected. Moves that skip stages are rejected too. A rejected code leaves the outputs as they were and raises an error flag that stays set until reset. After a skip, the block re-anchors on the new stage so that tracking resumes at the next valid step. The step counter can be cleared at any time through a dedicated input.

Top module: `hall_tach_dir`

## Requirements
- R1: While `rst` is high at a clock edge, the next outputs are `tach_o`=0, `dir_o`=0, `err_o`=0 and `step_cnt_o`=0.
- R2: The Hall code is read as {U,V,W} = `hall_i[2:0]`. The forward stage order is 101, 100, 110, 010, 011, 001, and after 001 it wraps back to 101. A move to the following stage in this order sets `dir_o` to 0 one clock later.
- R3: A move to the preceding stage in this order sets `dir_o` to 1 one clock later.
- R4: Every valid step (R2 or R3) inverts `tach_o` one clock later. The first valid code seen after reset sets `tach_o` to the XOR of the three Hall bits and does not count as a step.
- R5: Every valid step in either direction adds one to `step_cnt_o` one clock later. The 16-bit count wraps from 0xFFFF to 0.
- R6: `cnt_clr_i` high at a clock edge makes `step_cnt_o` 0 one clock later. This takes priority over a step in the same cycle. Direction and tachometer still follow that step.
- R7: The Hall codes 000 and 111 leave `tach_o`, `dir_o` and `step_cnt_o` unchanged and set `err_o` one clock later. The stage used for comparison is not moved.
- R8: A valid code two or three stages away from the reference leaves `tach_o`, `dir_o` and `step_cnt_o` unchanged and sets `err_o`. The reference moves to the new stage, so the next adjacent move counts from there.
- R9: A Hall code equal to the reference stage changes none of the outputs.
- R10: Once set, `err_o` stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| hall_i | input | 3 | Synchronised Hall bits {U,V,W} |
| cnt_clr_i | input | 1 | Clears the step counter |
| tach_o | output | 1 | Tachometer level, toggles per valid step |
| dir_o | output | 1 | 0 = U-V-W order, 1 = U-W-V order |
| err_o | output | 1 | Sticky flag for illegal codes and skipped stages |
| step_cnt_o | output | 16 | Count of valid steps |

## Verification
The assertions take the Hall bits to be already synchronised. They also take the bits to hold one settled code across each clock edge. Because of this, every code the block samples is treated as intended. A code may change on every cycle, since the design classifies each sample by itself. The stimulus changes `hall_i` and `cnt_clr_i` only on falling clock edges and presents exactly one code per cycle. Illegal codes and skips are applied deliberately, one at a time, so that each rejection can be seen at the outputs.

// File: rtl/hall_td_pkg.sv
package hall_td_pkg;

    localparam int NUM_STAGES = 6;
    localparam int IDX_W      = 3;

    typedef logic [2:0]       hall_code_t;
    typedef logic [IDX_W-1:0] stage_idx_t;

    typedef enum logic [1:0] {
        STEP_NONE,
        STEP_FWD,
        STEP_REV,
        STEP_BAD
    } step_kind_e;

    typedef struct packed {
        logic       valid;
        stage_idx_t idx;
    } stage_t;

    // Forward order of codes {U,V,W}: 101,100,110,010,011,001
    function automatic stage_t code_to_stage(hall_code_t code);
        stage_t s;
        s.valid = 1'b1;
        case (code)
            3'b101:  s.idx = 3'd0;
            3'b100:  s.idx = 3'd1;
            3'b110:  s.idx = 3'd2;
            3'b010:  s.idx = 3'd3;
            3'b011:  s.idx = 3'd4;
            3'b001:  s.idx = 3'd5;
            default: begin
                s.valid = 1'b0;
                s.idx   = 3'd0;
            end
        endcase
        return s;
    endfunction

    function automatic stage_idx_t stage_after(stage_idx_t i);
        return (i == stage_idx_t'(NUM_STAGES - 1)) ? '0 : i + 1'b1;
    endfunction

    function automatic stage_idx_t stage_before(stage_idx_t i);
        return (i == '0) ? stage_idx_t'(NUM_STAGES - 1) : i - 1'b1;
    endfunction

endpackage

// File: rtl/hall_stage_decode.sv
module hall_stage_decode
    import hall_td_pkg::*;
(
    input  hall_code_t code_i,
    output stage_t     stage_o
);

    always_comb begin
        stage_o = code_to_stage(code_i);
    end

endmodule

// File: rtl/hall_step_classify.sv
module hall_step_classify
    import hall_td_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  stage_t     cur_i,
    output step_kind_e kind_o,
    output logic       acquire_o
);

    stage_idx_t ref_q;
    logic       ref_valid_q;

    always_comb begin
        acquire_o = 1'b0;
        kind_o    = STEP_NONE;
        if (!cur_i.valid) begin
            kind_o = STEP_BAD;
        end else if (!ref_valid_q) begin
            acquire_o = 1'b1;
        end else if (cur_i.idx == ref_q) begin
            kind_o = STEP_NONE;
        end else if (cur_i.idx == stage_after(ref_q)) begin
            kind_o = STEP_FWD;
        end else if (cur_i.idx == stage_before(ref_q)) begin
            kind_o = STEP_REV;
        end else begin
            kind_o = STEP_BAD;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q       <= '0;
            ref_valid_q <= 1'b0;
        end else if (cur_i.valid) begin
            ref_q       <= cur_i.idx;
            ref_valid_q <= 1'b1;
        end
    end

    // R7
    bad_code_keeps_ref_chk: assert property (@(posedge clk) disable iff (rst)
        (!cur_i.valid) |=> $stable(ref_q));

endmodule

// File: rtl/hall_step_counter.sv
module hall_step_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] cnt_o
);

    typedef logic [CNT_W-1:0] cnt_t;
    cnt_t cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cnt_q <= '0;
        end else if (inc_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o = cnt_q;

    // R5
    cnt_advance_chk: assert property (@(posedge clk) disable iff (rst)
        (inc_i && !clr_i) |=> (cnt_q == cnt_t'($past(cnt_q) + 1'b1)));

    // R6
    cnt_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (cnt_q == '0));

    // R9
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!inc_i && !clr_i) |=> $stable(cnt_q));

endmodule

// File: rtl/hall_tach_dir.sv
module hall_tach_dir
    import hall_td_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       hall_i,
    input  logic             cnt_clr_i,
    output logic             tach_o,
    output logic             dir_o,
    output logic             err_o,
    output logic [CNT_W-1:0] step_cnt_o
);

    stage_t     cur_stage;
    step_kind_e kind;
    logic       acquire;
    logic       step_ok;
    logic       tach_q, dir_q, err_q;

    hall_stage_decode u_decode (
        .code_i  (hall_i),
        .stage_o (cur_stage)
    );

    hall_step_classify u_classify (
        .clk       (clk),
        .rst       (rst),
        .cur_i     (cur_stage),
        .kind_o    (kind),
        .acquire_o (acquire)
    );

    assign step_ok = (kind == STEP_FWD) || (kind == STEP_REV);

    hall_step_counter #(.CNT_W(CNT_W)) u_counter (
        .clk   (clk),
        .rst   (rst),
        .clr_i (cnt_clr_i),
        .inc_i (step_ok),
        .cnt_o (step_cnt_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tach_q <= 1'b0;
            dir_q  <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            if (acquire) begin
                tach_q <= ^hall_i;
            end
            case (kind)
                STEP_FWD: begin
                    tach_q <= ~tach_q;
                    dir_q  <= 1'b0;
                end
                STEP_REV: begin
                    tach_q <= ~tach_q;
                    dir_q  <= 1'b1;
                end
                STEP_BAD: err_q <= 1'b1;
                default:  ;
            endcase
        end
    end

    assign tach_o = tach_q;
    assign dir_o  = dir_q;
    assign err_o  = err_q;

    // R4
    tach_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        step_ok |=> (tach_o != $past(tach_o)));

    // R7
    illegal_code_err_chk: assert property (@(posedge clk) disable iff (rst)
        ((hall_i == 3'b000) || (hall_i == 3'b111)) |=> (err_o && $stable(tach_o) && $stable(dir_o)));

    // R8
    rejected_step_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (kind == STEP_BAD) |=> (err_o && $stable(tach_o) && $stable(dir_o)));

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err_o |=> err_o);

    // R2
    fwd_dir_chk: assert property (@(posedge clk) disable iff (rst)
        (kind == STEP_FWD) |=> !dir_o);

    // R3
    rev_dir_chk: assert property (@(posedge clk) disable iff (rst)
        (kind == STEP_REV) |=> dir_o);

endmodule

// File: tb/hall_tach_dir_tb_top.sv
module hall_tach_dir_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  hall;
    logic        clr;
    logic        tach, dir, err;
    logic [15:0] cnt;

    int vectors = 0;
    int misses  = 0;
    bit done    = 0;

    logic        e_tach, e_dir;
    logic [15:0] e_cnt;

    always #10 clk = ~clk;

    hall_tach_dir dut_i (
        .clk        (clk),
        .rst        (rst),
        .hall_i     (hall),
        .cnt_clr_i  (clr),
        .tach_o     (tach),
        .dir_o      (dir),
        .err_o      (err),
        .step_cnt_o (cnt)
    );

    function automatic logic [2:0] fwd_code(int i);
        case (i % 6)
            0: return 3'b101;
            1: return 3'b100;
            2: return 3'b110;
            3: return 3'b010;
            4: return 3'b011;
            default: return 3'b001;
        endcase
    endfunction

    task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_all(string req, logic e_err);
        check(req, "tach", {15'd0, tach}, {15'd0, e_tach});
        check(req, "dir",  {15'd0, dir},  {15'd0, e_dir});
        check(req, "err",  {15'd0, err},  {15'd0, e_err});
        check(req, "cnt",  cnt, e_cnt);
    endtask

    // apply a code for one clock; outputs are read at the following falling edge
    task automatic apply(logic [2:0] code, logic c);
        @(negedge clk);
        hall = code;
        clr  = c;
        @(negedge clk);
        clr  = 1'b0;
    endtask

    task automatic do_reset(logic [2:0] code);
        @(negedge clk);
        rst  = 1'b1;
        hall = code;
        clr  = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset_and_acquire();
        do_reset(3'b100);
        // R1: checked before the first unreset edge
        e_tach = 0; e_dir = 0; e_cnt = 0;
        check_all("R1", 1'b0);
        @(negedge clk);
        // R4: acquisition with parity of 100 = 1, no count
        e_tach = 1'b1;
        check_all("R4", 1'b0);
    endtask

    task automatic t_forward();
        for (int i = 2; i < 8; i++) begin
            apply(fwd_code(i), 1'b0);
            e_tach = ~e_tach; e_dir = 1'b0; e_cnt = e_cnt + 1;
            check_all("R2", 1'b0);
        end
    endtask

    task automatic t_reverse();
        // reference is stage 1 (100)
        for (int i = 0; i < 6; i++) begin
            apply(fwd_code(12 - i), 1'b0);
            e_tach = ~e_tach; e_dir = 1'b1; e_cnt = e_cnt + 1;
            check_all("R3", 1'b0);
        end
    endtask

    task automatic t_hold();
        // reference is stage 1 (100) after the reverse sweep
        for (int i = 0; i < 4; i++) begin
            apply(3'b100, 1'b0);
            check_all("R9", 1'b0);
        end
    endtask

    task automatic t_illegal();
        apply(3'b000, 1'b0);
        check_all("R7", 1'b1);
        apply(3'b111, 1'b0);
        check_all("R7", 1'b1);
        // back to the reference code: no step
        apply(3'b100, 1'b0);
        check_all("R7", 1'b1);
        // an adjacent forward step still counts and err stays set
        apply(3'b110, 1'b0);
        e_tach = ~e_tach; e_dir = 1'b0; e_cnt = e_cnt + 1;
        check_all("R10", 1'b1);
    endtask

    task automatic t_clear();
        apply(3'b110, 1'b1);
        e_cnt = 0;
        check_all("R6", 1'b1);
        // clear together with a reverse step
        apply(3'b100, 1'b1);
        e_tach = ~e_tach; e_dir = 1'b1; e_cnt = 0;
        check_all("R6", 1'b1);
    endtask

    task automatic t_jump();
        do_reset(3'b101);
        @(negedge clk);
        e_tach = 1'b0; e_dir = 1'b0; e_cnt = 0;
        check_all("R10", 1'b0);
        // reverse step 101 -> 001
        apply(3'b001, 1'b0);
        e_tach = 1'b1; e_dir = 1'b1; e_cnt = 1;
        check_all("R3", 1'b0);
        // skip two stages 001 -> 100
        apply(3'b100, 1'b0);
        check_all("R8", 1'b1);
        // skip three stages 100 -> 011
        apply(3'b011, 1'b0);
        check_all("R8", 1'b1);
        // forward from the new reference 011 -> 001
        apply(3'b001, 1'b0);
        e_tach = 1'b0; e_dir = 1'b0; e_cnt = 2;
        check_all("R8", 1'b1);
    endtask

    task automatic t_wrap();
        do_reset(3'b101);
        @(negedge clk);
        e_tach = 1'b0; e_dir = 1'b0;
        for (int i = 1; i <= 65535; i++) begin
            hall = fwd_code(i);
            @(negedge clk);
        end
        check("R5", "cnt at top", cnt, 16'hFFFF);
        check("R5", "tach", {15'd0, tach}, 16'd1);
        hall = fwd_code(65536);
        @(negedge clk);
        check("R5", "cnt wrap", cnt, 16'h0000);
        check("R5", "err", {15'd0, err}, 16'd0);
    endtask

    initial begin
        rst  = 1'b1;
        hall = 3'b100;
        clr  = 1'b0;
        t_reset_and_acquire();
        t_forward();
        t_reverse();
        t_hold();
        t_illegal();
        t_clear();
        t_jump();
        t_wrap();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            vectors++;
            misses++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

endmodule